// File: doc/BRIEF.md
# Multiplexed GPIO Pin Controller

This block owns nine general purpose pads. Eight of them can be given to an alternate function instead of GPIO: pad 0 to a wait output, pad 1 to a lock output, pads 2 and 3 to two chip selects, and pads 4 to 7 to local address bits 27, 26, 25 and 24. Pad 8 is GPIO only. The logic that produces the alternate functions is outside this block. Its output values and output enables arrive as plain inputs and are routed to the pads when selected.

A single 32-bit configuration word controls every pad. For each pad it holds an alternate-function select, a direction and an output data value. The same word reads back with live input levels in place of the data bits of pads that are GPIO inputs. A pad that is a GPIO output drives only while the bus-ownership input is high. A pad that is a GPIO input is synchronized and readable at all times. All pad controls and the read data are registered.

Top module: `gpio_pin_mux`

## Requirements
- R1: While `rst` is high, the configuration word resets to 32'h0024_9000. Pads 4 to 7 are on their alternate function, pads 0 to 3 and pad 8 are GPIO inputs, and all registered outputs are 0.
- R2: For pad n (0 to 7), bit 3n is the alternate select (1 = alternate), bit 3n+1 is the direction (1 = output) and bit 3n+2 is the data bit. Bits 24 and 31:27 are not stored and always read 0.
- R3: A GPIO output pad (select 0, direction 1) drives `pad_oe`=1 and `pad_out`=its data bit one clock edge after the condition holds, provided `bus_owned` is high.
- R4: A GPIO pad has `pad_oe`=0 one edge after `bus_owned` is sampled low, whatever its direction.
- R5: A GPIO input pad has `pad_oe`=0. Its data bit reads back the pad level after a SYNC_STAGES-flop synchronizer, independent of `bus_owned`.
- R6: The data bit of a GPIO output pad reads back the written value, not the pad level.
- R7: When pad n selects its alternate function, `pad_out[n]` and `pad_oe[n]` follow `alt_out[n]` and `alt_oe[n]` one edge later. `bus_owned`, direction and data are ignored.
- R8: Pad 8 has no alternate function. Bit 25 is its direction and bit 26 is its data, and a write to bit 24 has no effect on it.
- R9: The data bit of a pad on its alternate function reads back the stored written value.
- R10: A write on an edge changes `cfg_rdata` and the pad controls on the next edge. The per-pad outputs respond with exactly one edge of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data with live input levels |
| bus_owned | input | 1 | High while the device owns the local bus |
| alt_out | input | MUX_PINS | Alternate-function output values for pads 0 to 7 |
| alt_oe | input | MUX_PINS | Alternate-function output enables for pads 0 to 7 |
| pad_in | input | MUX_PINS+1 | Pad input levels |
| pad_out | output | MUX_PINS+1 | Registered pad output values |
| pad_oe | output | MUX_PINS+1 | Registered pad output enables |

## Verification
The bench builds the block with MUX_PINS=8, ALT_AT_RESET=8'hF0 and SYNC_STAGES=3. The deeper synchronizer makes input readback lag by four edges rather than three, so an off-by-one in the synchronizer chain cannot hide behind a two-stage default. The reference model runs every cycle and covers the reserved bits, pad 8 and a mix of random writes against random `bus_owned` toggling.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int CFG_W   = 32;
  localparam int FLD_W   = 3;
  localparam int SEL_OFS = 0;
  localparam int DIR_OFS = 1;
  localparam int DAT_OFS = 2;

  // Per-pad control as seen by the pad mux
  typedef struct packed {
    logic dat;
    logic dir;
    logic alt;
  } pin_cfg_t;

  // Reset word: alternate select set for pads flagged in alt_mask
  function automatic logic [CFG_W-1:0] cfg_reset_value(input int mux_pins,
                                                       input logic [CFG_W-1:0] alt_mask);
    logic [CFG_W-1:0] v;
    v = '0;
    for (int n = 0; n < mux_pins; n++) v[FLD_W*n+SEL_OFS] = alt_mask[n];
    return v;
  endfunction

  // Bits that hold state; every other bit reads zero
  function automatic logic [CFG_W-1:0] cfg_write_mask(input int mux_pins);
    logic [CFG_W-1:0] v;
    v = '0;
    for (int i = 0; i < FLD_W*mux_pins; i++) v[i] = 1'b1;
    v[FLD_W*mux_pins+DIR_OFS] = 1'b1;
    v[FLD_W*mux_pins+DAT_OFS] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= d;
    end
  end else begin : g_multi
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_mux_pkg::*;
#(
  parameter int                  MUX_PINS     = 8,
  parameter int                  PINS         = MUX_PINS + 1,
  parameter logic [MUX_PINS-1:0] ALT_AT_RESET = 8'hF0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic [PINS-1:0]            sync_in,
  output pin_cfg_t [PINS-1:0]        pin_cfg,
  output logic [CFG_W-1:0]           cfg_rdata
);

  localparam logic [CFG_W-1:0] RST_VAL  = cfg_reset_value(MUX_PINS, CFG_W'(ALT_AT_RESET));
  localparam logic [CFG_W-1:0] WR_MASK  = cfg_write_mask(MUX_PINS);
  localparam int               SOLO_DIR = FLD_W*MUX_PINS + DIR_OFS;
  localparam int               SOLO_DAT = FLD_W*MUX_PINS + DAT_OFS;

  logic [CFG_W-1:0] ctrl_q;
  logic [CFG_W-1:0] rd_nxt;

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= RST_VAL;
    else if (cfg_we) ctrl_q <= cfg_wdata & WR_MASK;
  end

  for (genvar p = 0; p < MUX_PINS; p++) begin : g_field
    assign pin_cfg[p] = '{alt: ctrl_q[FLD_W*p+SEL_OFS],
                          dir: ctrl_q[FLD_W*p+DIR_OFS],
                          dat: ctrl_q[FLD_W*p+DAT_OFS]};
  end
  assign pin_cfg[MUX_PINS] = '{alt: 1'b0, dir: ctrl_q[SOLO_DIR], dat: ctrl_q[SOLO_DAT]};

  // Readback: GPIO inputs show the synchronized level in their data bit
  always_comb begin
    rd_nxt = ctrl_q;
    for (int p = 0; p < MUX_PINS; p++) begin
      if (!ctrl_q[FLD_W*p+SEL_OFS] && !ctrl_q[FLD_W*p+DIR_OFS])
        rd_nxt[FLD_W*p+DAT_OFS] = sync_in[p];
    end
    if (!ctrl_q[SOLO_DIR]) rd_nxt[SOLO_DAT] = sync_in[MUX_PINS];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_nxt;
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~WR_MASK) == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(pin_cfg));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> pin_cfg[MUX_PINS].dir == $past(cfg_wdata[SOLO_DIR]));

  for (genvar p = 0; p < MUX_PINS; p++) begin : g_chk
    p_input_readback_r5: assert property (@(posedge clk) disable iff (rst)
      (!pin_cfg[p].alt && !pin_cfg[p].dir) |=> cfg_rdata[FLD_W*p+DAT_OFS] == $past(sync_in[p]));
    p_output_readback_r6: assert property (@(posedge clk) disable iff (rst)
      (!pin_cfg[p].alt && pin_cfg[p].dir) |=> cfg_rdata[FLD_W*p+DAT_OFS] == $past(pin_cfg[p].dat));
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_mux_pkg::*;
#(
  parameter int PINS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  pin_cfg_t [PINS-1:0] pin_cfg,
  input  logic                bus_owned,
  input  logic [PINS-1:0]     alt_out,
  input  logic [PINS-1:0]     alt_oe,
  output logic [PINS-1:0]     pad_out,
  output logic [PINS-1:0]     pad_oe
);

  logic [PINS-1:0] nxt_out;
  logic [PINS-1:0] nxt_oe;

  for (genvar p = 0; p < PINS; p++) begin : g_pad
    assign nxt_out[p] = pin_cfg[p].alt ? alt_out[p] : pin_cfg[p].dat;
    assign nxt_oe[p]  = pin_cfg[p].alt ? alt_oe[p]  : (pin_cfg[p].dir & bus_owned);

    p_owned_drive_r3: assert property (@(posedge clk) disable iff (rst)
      (!pin_cfg[p].alt && pin_cfg[p].dir && bus_owned)
        |=> pad_oe[p] && (pad_out[p] == $past(pin_cfg[p].dat)));

    p_unowned_released_r4: assert property (@(posedge clk) disable iff (rst)
      (!pin_cfg[p].alt && !bus_owned) |=> !pad_oe[p]);

    p_input_released_r5: assert property (@(posedge clk) disable iff (rst)
      (!pin_cfg[p].alt && !pin_cfg[p].dir) |=> !pad_oe[p]);

    p_alt_passthru_r7: assert property (@(posedge clk) disable iff (rst)
      pin_cfg[p].alt |=> (pad_out[p] == $past(alt_out[p])) && (pad_oe[p] == $past(alt_oe[p])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
#(
  parameter int                  MUX_PINS     = 8,
  parameter logic [MUX_PINS-1:0] ALT_AT_RESET = 8'hF0,
  parameter int                  SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                bus_owned,
  input  logic [MUX_PINS-1:0] alt_out,
  input  logic [MUX_PINS-1:0] alt_oe,
  input  logic [MUX_PINS:0]   pad_in,
  output logic [MUX_PINS:0]   pad_out,
  output logic [MUX_PINS:0]   pad_oe
);

  localparam int PINS = MUX_PINS + 1;

  logic [PINS-1:0]     sync_lvl;
  pin_cfg_t [PINS-1:0] pin_cfg;

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_lvl)
  );

  gpio_cfg_reg #(.MUX_PINS(MUX_PINS), .PINS(PINS), .ALT_AT_RESET(ALT_AT_RESET)) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sync_in   (sync_lvl),
    .pin_cfg   (pin_cfg),
    .cfg_rdata (cfg_rdata)
  );

  // Pad 8 has no alternate source: its select bit is tied low in the register
  gpio_pad_mux #(.PINS(PINS)) i_mux (
    .clk       (clk),
    .rst       (rst),
    .pin_cfg   (pin_cfg),
    .bus_owned (bus_owned),
    .alt_out   ({1'b0, alt_out}),
    .alt_oe    ({1'b0, alt_oe}),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

endmodule

// File: tb/test_gpio_pin_mux.sv
module test_gpio_pin_mux;

  localparam int          SYNC   = 3;
  localparam logic [31:0] RSTV   = 32'h0024_9000;
  localparam logic [31:0] MASK   = 32'h06FF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_owned = 1'b0;
  logic [7:0]  alt_out = '0;
  logic [7:0]  alt_oe = '0;
  logic [8:0]  pad_in = '0;
  logic [8:0]  pad_out;
  logic [8:0]  pad_oe;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  gpio_pin_mux #(.MUX_PINS(8), .ALT_AT_RESET(8'hF0), .SYNC_STAGES(SYNC)) i_gpio_pin_mux (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_owned(bus_owned), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] e_rd;
  logic [8:0]  e_out, e_oe;
  logic [8:0]  hist[$];
  bit          model_live = 1'b0;

  always @(posedge clk) begin
    logic [8:0]  s;
    logic [31:0] rd;
    logic [8:0]  po, oe;
    cyc++;
    if (rst) begin
      m_ctrl = RSTV;
      e_rd = '0; e_out = '0; e_oe = '0;
      hist.delete();
      repeat (SYNC) hist.push_front(9'h0);
      model_live = 1'b1;
    end else begin
      s  = hist[SYNC-1];
      rd = m_ctrl;
      for (int n = 0; n < 8; n++) begin
        if (m_ctrl[3*n]) begin
          po[n] = alt_out[n];
          oe[n] = alt_oe[n];
        end else begin
          po[n] = m_ctrl[3*n+2];
          oe[n] = m_ctrl[3*n+1] && bus_owned;
          if (!m_ctrl[3*n+1]) rd[3*n+2] = s[n];
        end
      end
      po[8] = m_ctrl[26];
      oe[8] = m_ctrl[25] && bus_owned;
      if (!m_ctrl[25]) rd[26] = s[8];
      e_rd = rd; e_out = po; e_oe = oe;
      if (cfg_we) m_ctrl = cfg_wdata & MASK;
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  // Cycle-exact comparison on every clock (R10 latency, R3/R7 values, R4/R5 enables)
  always @(negedge clk) begin
    if (model_live && !done) begin
      chk("R10 cfg_rdata", cfg_rdata, e_rd);
      chk("R3/R7 pad_out", 32'(pad_out), 32'(e_out));
      chk("R4/R5 pad_oe", 32'(pad_oe), 32'(e_oe));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R10 act=%0d exp<=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wr(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    logic [31:0] ein;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", cfg_rdata, RSTV);
    chk("R1 drivers off", 32'(pad_oe), 32'h0);

    // R2 / R8 / R9: reserved bits and bit 24 drop, alt data reads stored value
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2 R8 R9 readback of all-ones", cfg_rdata, 32'h06FF_FFFF);
    chk("R8 pad 8 released unowned", 32'(pad_oe[8]), 32'h0);
    bus_owned = 1'b1;
    @(negedge clk);
    chk("R8 pad 8 drives owned", 32'({pad_oe[8], pad_out[8]}), 32'h3);

    // R7: alt pads follow alt inputs, ignoring ownership, direction and data
    bus_owned = 1'b0; alt_out = 8'h5A; alt_oe = 8'hC3;
    @(negedge clk);
    chk("R7 alt out", 32'(pad_out[7:0]), 32'h5A);
    chk("R7 alt oe", 32'(pad_oe[7:0]), 32'hC3);

    // R5: inputs sampled while the bus is not owned
    wr(32'h0);
    pad_in = 9'h1A5;
    repeat (SYNC + 2) @(negedge clk);
    ein = '0;
    for (int n = 0; n < 8; n++) ein[3*n+2] = pad_in[n];
    ein[26] = pad_in[8];
    chk("R5 input readback", cfg_rdata, ein);
    chk("R5 inputs released", 32'(pad_oe), 32'h0);

    // R3 / R6 / R4: pad 0 as driven output
    pad_in = 9'h0; bus_owned = 1'b1;
    wr(32'h0000_0006);
    @(negedge clk);
    chk("R3 pad 0 drives", 32'({pad_oe, pad_out[0]}), 32'h003);
    chk("R6 output readback", 32'(cfg_rdata[2]), 32'h1);
    bus_owned = 1'b0;
    @(negedge clk);
    chk("R4 released unowned", 32'(pad_oe), 32'h0);

    // Random traffic under the per-cycle model
    for (int i = 0; i < 600; i++) begin
      bus_owned = 1'($urandom);
      pad_in    = 9'($urandom);
      alt_out   = 8'($urandom);
      alt_oe    = 8'($urandom);
      if ((($urandom) & 3) == 0) wr($urandom);
      else @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule